// File: doc/BRIEF.md
# Four-Function ALU with Status Flags

This is a purely combinational arithmetic logic unit with operands of parameter width `W` (32 bits by default). A 2-bit operation code selects one of four results: bitwise AND, bitwise OR, sum or difference. Alongside the result, the block drives four status flags: zero, carry, signed overflow and negative.

Addition and subtraction share one ripple-carry adder. For subtraction, the second operand is inverted bit by bit and the adder's carry-in is forced to one, so the adder computes A + ~B + 1. The low opcode bit picks AND or OR on the logic side and add or subtract on the arithmetic side. The high opcode bit then picks between the logic result and the arithmetic result. The block has no registers, so every output settles within the same cycle as its inputs.

Top module: `flag_alu`

## Requirements
- R1: With op_i = 2'b00, res_o equals a_i AND b_i.
- R2: With op_i = 2'b01, res_o equals a_i OR b_i.
- R3: With op_i = 2'b10, res_o equals (a_i + b_i) mod 2^W, and carry_o is the carry out of the most significant adder stage.
- R4: With op_i = 2'b11, res_o equals (a_i - b_i) mod 2^W, and carry_o is 1 exactly when no borrow occurs, that is, when a_i >= b_i taken as unsigned numbers.
- R5: For op_i[1] = 1, ovf_o is 1 exactly when the true signed (two's complement) sum or difference falls outside the range of a W-bit signed number. For op_i[1] = 0, carry_o and ovf_o have no defined value.
- R6: neg_o equals bit W-1 of res_o for every operation.
- R7: zero_o is 1 exactly when every bit of res_o is 0, for every operation, including all-zero inputs.
- R8: The block works at W = 4. For example, 4'd7 + 4'd7 gives res_o = 4'b1110 with ovf_o = 1 and carry_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| op_i | input | 2 | Operation: 00 AND, 01 OR, 10 add, 11 subtract |
| res_o | output | W | Selected result |
| zero_o | output | 1 | All bits of the result are clear |
| carry_o | output | 1 | Carry out of the top adder stage |
| ovf_o | output | 1 | Signed overflow of the add or subtract |
| neg_o | output | 1 | Most significant bit of the result |

## Verification
The block holds no state, so an internal fault appears at the ports in the same cycle as the input pattern that excites it. Examples are a broken carry link, a mis-steered inversion, or the overflow taken from the raw operand instead of the inverted one. A broken carry link shows up only for operand pairs whose carries propagate through that stage. For that reason the 4-bit build is swept over every operand pair and opcode, and the 32-bit build is driven with random operands plus boundary values such as the signed extremes, all ones, and equal operands. The overflow flag is the most likely to hide a fault. It is compared against a signed-range model for both add and subtract, because the two operations disagree whenever the operand signs differ.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         neg_o
);

  localparam int MSB = W - 1;

  logic [W-1:0] b_x;
  logic [W-1:0] sum;
  logic [W-1:0] logic_r;
  logic [W:0]   cy;

  assign b_x   = b_i ^ {W{op_i[0]}};
  assign cy[0] = op_i[0];

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = a_i[i] ^ b_x[i] ^ cy[i];
    assign cy[i+1] = (a_i[i] & b_x[i]) | (cy[i] & (a_i[i] ^ b_x[i]));
  end

  assign logic_r = op_i[0] ? (a_i | b_i) : (a_i & b_i);
  assign res_o   = op_i[1] ? sum : logic_r;

  assign carry_o = cy[W];
  assign ovf_o   = (~a_i[MSB] & ~b_x[MSB] &  sum[MSB]) |
                   ( a_i[MSB] &  b_x[MSB] & ~sum[MSB]);
  assign neg_o   = res_o[MSB];
  assign zero_o  = ~|res_o;

  always_comb begin
    if (op_i == 2'b00) AST_AND_RESULT: assert (res_o == (a_i & b_i)); // R1
    if (op_i == 2'b01) AST_OR_RESULT: assert (res_o == (a_i | b_i)); // R2
    if (op_i == 2'b10) AST_ADD_SUM: assert ({carry_o, res_o} == ({1'b0, a_i} + {1'b0, b_i})); // R3
    if (op_i == 2'b11) AST_SUB_DIFF: assert (res_o == a_i - b_i); // R4
    if (op_i == 2'b11) AST_SUB_NO_BORROW: assert (carry_o == (a_i >= b_i)); // R4
    if (op_i == 2'b10) AST_ADD_OVERFLOW: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB]))); // R5
    if (op_i == 2'b11) AST_SUB_OVERFLOW: assert (ovf_o == ((a_i[MSB] != b_i[MSB]) && (res_o[MSB] != a_i[MSB]))); // R5
    AST_NEG_SIGN: assert (neg_o == ($signed(res_o) < 0)); // R6
    AST_ZERO_FLAG: assert (zero_o == (res_o == '0)); // R7
  end

endmodule

// File: tb/flag_alu_bench.sv
module flag_alu_bench;

  typedef struct {
    bit          narrow;
    logic [1:0]  op;
    logic [31:0] res;
    logic        zero, carry, ovf, neg;
    string       tag;
  } exp_t;

  logic clk = 0;
  logic rst = 1;
  always #10 clk = ~clk;

  logic [31:0] a_d = '0, b_d = '0;
  logic [1:0]  op_d = '0;

  logic [31:0] res_w;  logic z_w, c_w, v_w, n_w;
  logic [3:0]  res_n;  logic z_n, c_n, v_n, n_n;

  flag_alu #(.W(32)) u_flag_alu (
    .a_i(a_d), .b_i(b_d), .op_i(op_d),
    .res_o(res_w), .zero_o(z_w), .carry_o(c_w), .ovf_o(v_w), .neg_o(n_w));

  flag_alu #(.W(4)) u_flag_alu_n4 (
    .a_i(a_d[3:0]), .b_i(b_d[3:0]), .op_i(op_d),
    .res_o(res_n), .zero_o(z_n), .carry_o(c_n), .ovf_o(v_n), .neg_o(n_n));

  exp_t q[$];
  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input bit narrow, input logic [1:0] op,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    int w;
    longint unsigned mask, aa, bb, s;
    longint sa, sb, sr, hi, lo;
    exp_t e;
    w    = narrow ? 4 : 32;
    mask = (64'd1 << w) - 1;
    aa   = a & mask;
    bb   = b & mask;
    case (op)
      2'b00:   s = aa & bb;
      2'b01:   s = aa | bb;
      2'b10:   s = aa + bb;
      default: s = aa + ((~bb) & mask) + 1;
    endcase
    sa = aa[w-1] ? longint'(aa) - (longint'(1) << w) : longint'(aa);
    sb = bb[w-1] ? longint'(bb) - (longint'(1) << w) : longint'(bb);
    sr = (op == 2'b10) ? sa + sb : sa - sb;
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -(longint'(1) << (w - 1));
    e.narrow = narrow;
    e.op     = op;
    e.res    = 32'(s & mask);
    e.carry  = s[w];
    e.ovf    = (sr > hi) || (sr < lo);
    e.neg    = e.res[w-1];
    e.zero   = (e.res == 0);
    e.tag    = tag;
    @(posedge clk);
    a_d  = a;
    b_d  = b;
    op_d = op;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      string rt;
      logic [31:0] r; logic z, c, v, n;
      e = q.pop_front();
      if (e.narrow) begin r = {28'd0, res_n}; z = z_n; c = c_n; v = v_n; n = n_n; end
      else          begin r = res_w;          z = z_w; c = c_w; v = v_w; n = n_w; end
      case (e.op)
        2'b00:   rt = "R1";
        2'b01:   rt = "R2";
        2'b10:   rt = "R3";
        default: rt = "R4";
      endcase
      if (e.tag != "") rt = e.tag;
      chk(rt, "result", r, e.res);
      chk(e.tag != "" ? e.tag : "R7", "zero", z, e.zero);
      chk(e.tag != "" ? e.tag : "R6", "negative", n, e.neg);
      if (e.op[1]) begin
        chk(rt, "carry", c, e.carry);
        chk(e.tag != "" ? e.tag : "R5", "overflow", v, e.ovf);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 0;
    drive(0, 2'b00, 32'h0, 32'h0, "R7");
    drive(1, 2'b10, 32'h7, 32'h7, "R8");
    drive(1, 2'b11, 32'h8, 32'h1, "R8");
    drive(0, 2'b10, 32'hFFFF_FFFF, 32'h1, "R3");
    drive(0, 2'b10, 32'h7FFF_FFFF, 32'h1, "R5");
    drive(0, 2'b11, 32'h8000_0000, 32'h1, "R5");
    drive(0, 2'b11, 32'h1234_5678, 32'h1234_5678, "R7");
    drive(0, 2'b11, 32'h0, 32'h1, "R4");
    drive(0, 2'b11, 32'h0, 32'h8000_0000, "R5");
    drive(0, 2'b01, 32'h8000_0000, 32'h0, "R6");
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          drive(1, 2'(op), 32'(a), 32'(b), "");
    for (int k = 0; k < 2000; k++)
      drive(0, 2'($urandom_range(0, 3)), $urandom, $urandom, "");
    for (int k = 0; k < 200; k++)
      drive(0, 2'($urandom_range(2, 3)), {$urandom_range(0, 1) ? 4'h7 : 4'h8, 28'($urandom)},
            {$urandom_range(0, 1) ? 4'h7 : 4'h8, 28'($urandom)}, "");
    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule